// File: doc/BRIEF.md
# Cipher Operand Byte-Order Swapper

This block sits between a host datapath and a block-cipher core and rearranges the bytes of the 128-bit quantities that cross it. On the way into the core it reorders a 256-bit key, a 128-bit initialisation vector and a 128-bit data block. On the way out of the core it reorders the 128-bit result block. Both directions are registered, so each adds one cycle of latency.

A single 11-bit configuration word sets the reordering. For each of five lanes (key upper half, key lower half, IV, inbound data, outbound result) one bit reverses the bytes inside every 32-bit word, and another bit reverses the order of the four 32-bit words inside the 128-bit block. A further bit exchanges the two 128-bit halves of the key. The configuration resets to zero, which passes every lane through unchanged. Setting all bits (0x7FF) gives a full byte reversal on every lane.

Byte p of a block means bits [8p+7:8p], and word w means bits [32w+31:32w].

Top module: `bo_swapper`

## Requirements
- R1: After reset `core_valid` and `host_valid` are low, every data output is zero and the configuration is 0x000, so later transfers pass through unchanged.
- R2: A configuration written with `cfg_we` high at a clock edge applies to transfers captured at later edges. A transfer captured at the same edge as the write uses the previous configuration.
- R3: `core_valid` equals `ld_valid` one cycle earlier and `host_valid` equals `rs_valid` one cycle earlier. The reordered data appear in the same cycle as the delayed strobe.
- R4: When its strobe is low, a direction's data outputs keep their previous values whatever its inputs do.
- R5: The low bit of a lane's control pair reverses the bytes inside each word: byte b of a word moves to byte 3-b of the same word.
- R6: The high bit of a lane's control pair reverses the words: word w moves to word 3-w, with the bytes inside each word kept in order.
- R7: When both bits of a lane's pair are set, byte p of the block moves to byte 15-p.
- R8: Bit 10 exchanges the key halves first. Bits 9:8 then act on the upper output half `core_key[255:128]` and bits 7:6 act on the lower output half.
- R9: The control pairs are independent. Bits 5:4 act only on the IV, bits 3:2 only on the outbound result and bits 1:0 only on the inbound data.
- R10: Configuration 0x7FF reverses all 16 bytes of the IV, the inbound data, the outbound result and each key half, and also exchanges the key halves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 11 | New configuration word |
| ld_valid | input | 1 | Inbound transfer strobe |
| ld_key | input | 256 | Key from the host |
| ld_iv | input | 128 | IV from the host |
| ld_data | input | 128 | Data block from the host |
| core_valid | output | 1 | Inbound strobe delayed by one cycle |
| core_key | output | 256 | Reordered key to the core |
| core_iv | output | 128 | Reordered IV to the core |
| core_data | output | 128 | Reordered data to the core |
| rs_valid | input | 1 | Result strobe from the core |
| rs_data | input | 128 | Result block from the core |
| host_valid | output | 1 | Result strobe delayed by one cycle |
| host_data | output | 128 | Reordered result to the host |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, four bytes per word and four words per block. This puts every 11-bit configuration value within reach, and the table of configurations includes the single-bit, mixed and all-ones words. Its reference model works byte by byte: it computes the source word and the source byte for each output byte, while the RTL does the reordering as two stacked permutations. Directed tests cover a write that coincides with a transfer, holding the outputs while the strobe is low, and a reset after the configuration has been changed.

// File: rtl/bo_pkg.sv
package bo_pkg;
  localparam int CFG_W = 11;

  // Field order is the bit position: key_xchg is bit 10, in_bsw is bit 0.
  typedef struct packed {
    logic key_xchg;
    logic khi_wrev;
    logic khi_bsw;
    logic klo_wrev;
    logic klo_bsw;
    logic iv_wrev;
    logic iv_bsw;
    logic out_wrev;
    logic out_bsw;
    logic in_wrev;
    logic in_bsw;
  } bo_cfg_t;
endpackage

// File: rtl/bo_cfg_reg.sv
module bo_cfg_reg
  import bo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output bo_cfg_t          cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cfg <= '0;
    else if (we) cfg <= bo_cfg_t'(wdata);
  end
endmodule

// File: rtl/bo_lane.sv
module bo_lane #(
  parameter int BYTE_W = 8,
  parameter int BPW    = 4,
  parameter int WPB    = 4,
  localparam int WORD_W = BYTE_W * BPW,
  localparam int BLK_W  = WORD_W * WPB
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic             byte_sw,
  input  logic             word_rev,
  output logic [BLK_W-1:0] blk_o
);
  logic [BLK_W-1:0] bsw_blk;
  logic [BLK_W-1:0] stage1;
  logic [BLK_W-1:0] wrev_blk;

  // Stage 1: reverse the bytes inside every word.
  for (genvar w = 0; w < WPB; w++) begin : g_word
    for (genvar b = 0; b < BPW; b++) begin : g_byte
      assign bsw_blk[w*WORD_W + b*BYTE_W +: BYTE_W] =
        blk_i[w*WORD_W + (BPW-1-b)*BYTE_W +: BYTE_W];
    end
  end
  assign stage1 = byte_sw ? bsw_blk : blk_i;

  // Stage 2: reverse the word order inside the block.
  for (genvar w = 0; w < WPB; w++) begin : g_wrev
    assign wrev_blk[w*WORD_W +: WORD_W] = stage1[(WPB-1-w)*WORD_W +: WORD_W];
  end
  assign blk_o = word_rev ? wrev_blk : stage1;
endmodule

// File: rtl/bo_swapper.sv
module bo_swapper
  import bo_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BPW    = 4,
  parameter int WPB    = 4,
  localparam int BLK_W = BYTE_W * BPW * WPB,
  localparam int KEY_W = 2 * BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [10:0]      cfg_wdata,
  input  logic             ld_valid,
  input  logic [KEY_W-1:0] ld_key,
  input  logic [BLK_W-1:0] ld_iv,
  input  logic [BLK_W-1:0] ld_data,
  output logic             core_valid,
  output logic [KEY_W-1:0] core_key,
  output logic [BLK_W-1:0] core_iv,
  output logic [BLK_W-1:0] core_data,
  input  logic             rs_valid,
  input  logic [BLK_W-1:0] rs_data,
  output logic             host_valid,
  output logic [BLK_W-1:0] host_data
);
  bo_cfg_t          cfg;
  logic [CFG_W-1:0] cfg_q;       // named for the checker
  logic [KEY_W-1:0] key_x;       // key after the half exchange
  logic [BLK_W-1:0] khi_n, klo_n, iv_n, din_n, dout_n;

  bo_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );
  assign cfg_q = cfg;

  assign key_x = cfg.key_xchg ? {ld_key[BLK_W-1:0], ld_key[KEY_W-1:BLK_W]} : ld_key;

  bo_lane #(.BYTE_W(BYTE_W), .BPW(BPW), .WPB(WPB)) u_khi (
    .blk_i(key_x[KEY_W-1:BLK_W]), .byte_sw(cfg.khi_bsw), .word_rev(cfg.khi_wrev), .blk_o(khi_n));
  bo_lane #(.BYTE_W(BYTE_W), .BPW(BPW), .WPB(WPB)) u_klo (
    .blk_i(key_x[BLK_W-1:0]), .byte_sw(cfg.klo_bsw), .word_rev(cfg.klo_wrev), .blk_o(klo_n));
  bo_lane #(.BYTE_W(BYTE_W), .BPW(BPW), .WPB(WPB)) u_iv (
    .blk_i(ld_iv), .byte_sw(cfg.iv_bsw), .word_rev(cfg.iv_wrev), .blk_o(iv_n));
  bo_lane #(.BYTE_W(BYTE_W), .BPW(BPW), .WPB(WPB)) u_din (
    .blk_i(ld_data), .byte_sw(cfg.in_bsw), .word_rev(cfg.in_wrev), .blk_o(din_n));
  bo_lane #(.BYTE_W(BYTE_W), .BPW(BPW), .WPB(WPB)) u_dout (
    .blk_i(rs_data), .byte_sw(cfg.out_bsw), .word_rev(cfg.out_wrev), .blk_o(dout_n));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_valid <= 1'b0;
      core_key   <= '0;
      core_iv    <= '0;
      core_data  <= '0;
    end else begin
      core_valid <= ld_valid;
      if (ld_valid) begin
        core_key  <= {khi_n, klo_n};
        core_iv   <= iv_n;
        core_data <= din_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_valid <= 1'b0;
      host_data  <= '0;
    end else begin
      host_valid <= rs_valid;
      if (rs_valid) host_data <= dout_n;
    end
  end
endmodule

// File: rtl/bo_swapper_chk.sv
module bo_swapper_chk #(
  parameter int BLK_W = 128,
  localparam int KEY_W = 2 * BLK_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [10:0]      cfg_wdata,
  input logic [10:0]      cfg_q,
  input logic             ld_valid,
  input logic [KEY_W-1:0] ld_key,
  input logic [BLK_W-1:0] ld_iv,
  input logic             rs_valid,
  input logic             core_valid,
  input logic [KEY_W-1:0] core_key,
  input logic [BLK_W-1:0] core_iv,
  input logic [BLK_W-1:0] core_data,
  input logic             host_valid
);
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) && $past(rst_n) |-> cfg_q == $past(cfg_wdata));

  p_core_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> core_valid == $past(ld_valid));

  p_host_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> host_valid == $past(rs_valid));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> $stable(core_data) && $stable(core_iv));

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ld_valid) && $past(cfg_q) == 11'h000 |-> core_iv == $past(ld_iv));

  p_key_xchg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ld_valid) && $past(cfg_q) == 11'h400 |->
      core_key == {$past(ld_key[BLK_W-1:0]), $past(ld_key[KEY_W-1:BLK_W])});
endmodule

bind bo_swapper bo_swapper_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
  .ld_valid(ld_valid), .ld_key(ld_key), .ld_iv(ld_iv), .rs_valid(rs_valid),
  .core_valid(core_valid), .core_key(core_key), .core_iv(core_iv),
  .core_data(core_data), .host_valid(host_valid)
);

// File: tb/bo_swapper_tb.sv
module bo_swapper_tb;
  localparam int CLK_P = 10;
  localparam int NTAB  = 10;

  localparam logic [10:0] CFG_TAB [NTAB] = '{
    11'h000, 11'h001, 11'h002, 11'h003, 11'h00C,
    11'h030, 11'h400, 11'h3C0, 11'h555, 11'h7FF };
  localparam logic [7:0] SEED_TAB [NTAB] = '{
    8'h00, 8'h11, 8'h23, 8'h35, 8'h47, 8'h59, 8'h6B, 8'h7D, 8'h8F, 8'hA1 };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [10:0]  cfg_wdata = '0;
  logic         ld_valid = 1'b0;
  logic [255:0] ld_key = '0;
  logic [127:0] ld_iv = '0;
  logic [127:0] ld_data = '0;
  logic         rs_valid = 1'b0;
  logic [127:0] rs_data = '0;
  logic         core_valid, host_valid;
  logic [255:0] core_key;
  logic [127:0] core_iv, core_data, host_data;

  int checks = 0;
  int errors = 0;
  logic [10:0] cur_cfg;

  always #(CLK_P/2) clk = ~clk;

  bo_swapper u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ld_valid(ld_valid), .ld_key(ld_key), .ld_iv(ld_iv), .ld_data(ld_data),
    .core_valid(core_valid), .core_key(core_key), .core_iv(core_iv), .core_data(core_data),
    .rs_valid(rs_valid), .rs_data(rs_data), .host_valid(host_valid), .host_data(host_data)
  );

  // Byte-indexed reference: output byte p takes its word and byte from the mirrored positions.
  function automatic logic [127:0] ref_blk(logic [127:0] x, logic wrev, logic bsw);
    logic [127:0] r;
    for (int p = 0; p < 16; p++) begin
      int sw, sb;
      sw = wrev ? 3 - p / 4 : p / 4;
      sb = bsw ? 3 - p % 4 : p % 4;
      r[p*8 +: 8] = x[(sw*4 + sb)*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [255:0] ref_key(logic [255:0] k, logic [10:0] c);
    logic [255:0] kx;
    kx = c[10] ? {k[127:0], k[255:128]} : k;
    return {ref_blk(kx[255:128], c[9], c[8]), ref_blk(kx[127:0], c[7], c[6])};
  endfunction

  function automatic logic [127:0] mk(logic [7:0] s);
    logic [127:0] r;
    for (int p = 0; p < 16; p++) r[p*8 +: 8] = s + 8'(p * 13);
    return r;
  endfunction

  task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(logic [10:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = v;
  endtask

  // Presents one transfer on both directions and samples after the capturing edge.
  task automatic xfer(logic [7:0] s);
    ld_valid = 1'b1; rs_valid = 1'b1;
    ld_key = {mk(s ^ 8'hC3), mk(s)}; ld_iv = mk(s + 8'h40);
    ld_data = mk(s + 8'h80); rs_data = mk(s + 8'hB0);
    @(negedge clk);
    ld_valid = 1'b0; rs_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_cfg = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valids", {254'd0, core_valid, host_valid}, '0);
    chk("R1", "core_key", core_key, '0);
    chk("R1", "core_iv/data", {core_iv, core_data}, '0);
    chk("R1", "host_data", {128'd0, host_data}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(8'h05);
    chk("R1", "passthru key after reset", core_key, ld_key);
    chk("R3", "core_valid", {255'd0, core_valid}, 256'd1);
    chk("R3", "host_valid", {255'd0, host_valid}, 256'd1);

    // Table walk over configurations: R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NTAB; i++) begin
      write_cfg(CFG_TAB[i]);
      xfer(SEED_TAB[i]);
      chk("R8", "core_key", core_key, ref_key(ld_key, cur_cfg));
      chk("R9", "core_iv", {128'd0, core_iv}, {128'd0, ref_blk(ld_iv, cur_cfg[5], cur_cfg[4])});
      chk("R5", "core_data", {128'd0, core_data}, {128'd0, ref_blk(ld_data, cur_cfg[1], cur_cfg[0])});
      chk("R6", "host_data", {128'd0, host_data}, {128'd0, ref_blk(rs_data, cur_cfg[3], cur_cfg[2])});
    end

    // R10 / R7: literal full reversal with 0x7FF (config still 0x7FF from the table)
    ld_valid = 1'b1; rs_valid = 1'b1;
    ld_iv   = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    ld_data = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    rs_data = 128'hffeeddcc_bbaa9988_77665544_33221100;
    ld_key  = {128'h1f1e1d1c_1b1a1918_17161514_13121110, 128'h0f0e0d0c_0b0a0908_07060504_03020100};
    @(negedge clk);
    ld_valid = 1'b0; rs_valid = 1'b0;
    chk("R7", "iv full reverse", {128'd0, core_iv}, {128'd0, 128'h00010203_04050607_08090a0b_0c0d0e0f});
    chk("R10", "data full reverse", {128'd0, core_data}, {128'd0, 128'h00010203_04050607_08090a0b_0c0d0e0f});
    chk("R10", "result full reverse", {128'd0, host_data}, {128'd0, 128'h00112233_44556677_8899aabb_ccddeeff});
    chk("R10", "key exchange+reverse", core_key,
        {128'h00010203_04050607_08090a0b_0c0d0e0f, 128'h10111213_14151617_18191a1b_1c1d1e1f});

    // R5 literal: byte swap only on IV (bit 4)
    write_cfg(11'h010);
    xfer(8'h00);
    ld_valid = 1'b1; ld_iv = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R5", "iv byte swap literal", {128'd0, core_iv}, {128'd0, 128'h0c0d0e0f_08090a0b_04050607_00010203});

    // R6 literal: word reversal only on IV (bit 5)
    write_cfg(11'h020);
    ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R6", "iv word reverse literal", {128'd0, core_iv}, {128'd0, 128'h03020100_07060504_0b0a0908_0f0e0d0c});

    // R4: outputs hold while strobes are low
    begin
      logic [127:0] hold_iv, hold_res;
      hold_iv = core_iv; hold_res = host_data;
      ld_iv = ~ld_iv; rs_data = ~rs_data;
      repeat (3) @(negedge clk);
      chk("R4", "core_iv held", {128'd0, core_iv}, {128'd0, hold_iv});
      chk("R4", "host_data held", {128'd0, host_data}, {128'd0, hold_res});
      chk("R3", "valids low", {254'd0, core_valid, host_valid}, '0);
    end

    // R2: write in the same cycle as a transfer uses the old configuration (0x020)
    cfg_we = 1'b1; cfg_wdata = 11'h000;
    ld_valid = 1'b1; ld_iv = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    @(negedge clk);
    cfg_we = 1'b0; ld_valid = 1'b0;
    chk("R2", "same-cycle uses old cfg", {128'd0, core_iv}, {128'd0, 128'h03020100_07060504_0b0a0908_0f0e0d0c});
    ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R2", "next transfer uses new cfg", {128'd0, core_iv}, {128'd0, ld_iv});

    // R1: reset after a nonzero configuration returns to pass-through
    write_cfg(11'h7FF);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "outputs cleared", {core_iv, core_data}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    cur_cfg = '0;
    xfer(8'h3C);
    chk("R1", "cfg cleared by reset", core_key, ld_key);
    chk("R1", "result passthru", {128'd0, host_data}, {128'd0, rs_data});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule